// File: doc/BRIEF.md
# Integrating Amplitude Control Loop

This block regulates an amplifier's output level with a pure integral control law. On every control tick, which is nominally once per millisecond, it takes the difference between a programmed target level and the measured level. It adds that difference into a running accumulator, scales the accumulated value by a programmable fixed-point gain, and issues the result as a PWM duty command together with a one-cycle valid strobe. The PWM modulator that consumes the command is a separate block.

The gain is the only loop filter. A small gain averages the error over many ticks, so measurement noise such as beat tones between the carrier and an interferer is rejected better, but the level settles more slowly. The error captured on one tick first reaches the duty command on the following tick. With a plant whose response is proportional to the previous duty, this extra sample of delay makes the loop overshoot at moderate gain and oscillate at high gain. The accumulator is clamped so that it never wraps. It also stops integrating upward while the command is pinned at full scale, which lets the duty leave saturation without a long unwind.

Top module: `amp_level_loop`

## Requirements
- R1: After reset, `duty` is 0 and `duty_vld` is 0, and the held error and the accumulator are both zero.
- R2: `duty_vld` is high for exactly the one clock cycle that follows each clock cycle in which `meas_tick` is high, and is low at all other times.
- R3: `duty` changes only on a cycle where `duty_vld` is high. Between ticks it holds its value.
- R4: The error `setpoint - meas` sampled on tick n is first added into the accumulator on tick n+1. The duty published after tick 1 following reset is therefore 0, even when the error is non-zero.
- R5: On each tick, duty = min(floor(acc * k_gain / 4096), 4095). `acc` is the accumulator after the update and `k_gain` is unsigned with 12 fractional bits, so 4096 means a gain of 1.0. The gain is read on the tick.
- R6: The accumulator never drops below zero. Negative errors that would take it below zero leave it at 0, so the next positive error raises the duty at once.
- R7: The duty saturates at 4095, the full-scale count of the 12-bit output, and never wraps.
- R8: If the previous duty was 4095 and the error being added is positive, the accumulator holds its value. A sustained positive error during saturation therefore stores at most one step of excess.
- R9: With a plant whose measured level equals the previous duty, a setpoint of 1000 and a gain of 0.25 (1024), the duty settles to within 10 counts of 1000 within 100 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| setpoint | input | 16 | Target level, unsigned |
| meas | input | 16 | Measured level, unsigned, sampled when `meas_tick` is high |
| meas_tick | input | 1 | Control-tick strobe, one cycle wide |
| k_gain | input | 16 | Loop gain, unsigned, 12 fractional bits |
| duty | output | 12 | Saturated PWM duty command |
| duty_vld | output | 1 | High for one cycle when a new duty is published |

## Verification
A fault in the held error shows up one tick late: the duty published on the tick after the stimulus departs from the expected value. A fault in the accumulator shows up in every later duty. Clamp faults stay hidden until the boundary is exercised. A lost floor at zero appears when a positive error follows a run of negative ones, because the duty then stays at zero for too long. Missing anti-windup appears when an error of the opposite sign follows a saturated run, because the duty leaves full scale ticks later than expected. The bench tracks an expected duty for every tick, so any divergence is reported on the first tick where it appears.

// File: rtl/amp_loop_pkg.sv
package amp_loop_pkg;
  localparam int unsigned LVL_W_DEF  = 16;
  localparam int unsigned K_W_DEF    = 16;
  localparam int unsigned K_FRAC_DEF = 12;
  localparam int unsigned DUTY_W_DEF = 12;
  localparam int unsigned ACC_W_DEF  = 24;
  localparam int unsigned SYNC_DEF   = 2;
endpackage

// File: rtl/amp_err_stage.sv
module amp_err_stage #(
  parameter int unsigned LVL_W = amp_loop_pkg::LVL_W_DEF,
  localparam int unsigned ERR_W = LVL_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick,
  input  logic [LVL_W-1:0]        setpoint,
  input  logic [LVL_W-1:0]        meas,
  output logic signed [ERR_W-1:0] err_q
);
  logic signed [ERR_W-1:0] err_d;

  always_comb begin
    err_d = err_q;
    if (tick) begin
      err_d = $signed({1'b0, setpoint}) - $signed({1'b0, meas});
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= '0;
    end else if (tick) begin
      err_q <= err_d;
    end
  end

  p_err_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(err_q));
endmodule

// File: rtl/amp_integrator.sv
module amp_integrator #(
  parameter int unsigned LVL_W = amp_loop_pkg::LVL_W_DEF,
  parameter int unsigned ACC_W = amp_loop_pkg::ACC_W_DEF,
  localparam int unsigned ERR_W = LVL_W + 1,
  localparam int unsigned SUM_W = ACC_W + 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick,
  input  logic signed [ERR_W-1:0] err_q,
  input  logic                    sat_q,
  output logic [ACC_W-1:0]        acc_q,
  output logic [ACC_W-1:0]        acc_nxt
);
  localparam logic [ACC_W-1:0] ACC_MAX = '1;

  logic signed [SUM_W-1:0] err_ext;
  logic signed [SUM_W-1:0] sum;
  logic                    hold_up;

  always_comb begin
    err_ext = {{(SUM_W-ERR_W){err_q[ERR_W-1]}}, err_q};
    sum     = $signed({2'b00, acc_q}) + err_ext;
    hold_up = sat_q && (err_q > 0);
    if (hold_up) begin
      acc_nxt = acc_q;
    end else if (sum < 0) begin
      acc_nxt = '0;
    end else if (sum > $signed({2'b00, ACC_MAX})) begin
      acc_nxt = ACC_MAX;
    end else begin
      acc_nxt = sum[ACC_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (tick) begin
      acc_q <= acc_nxt;
    end
  end

  p_acc_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sat_q && (err_q > 0)) |=> (acc_q == $past(acc_q)));
  p_acc_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(acc_q));
  p_acc_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (err_q < 0) && (acc_q == '0)) |=> (acc_q == '0));
endmodule

// File: rtl/amp_gain_scale.sv
module amp_gain_scale #(
  parameter int unsigned ACC_W  = amp_loop_pkg::ACC_W_DEF,
  parameter int unsigned K_W    = amp_loop_pkg::K_W_DEF,
  parameter int unsigned K_FRAC = amp_loop_pkg::K_FRAC_DEF,
  parameter int unsigned DUTY_W = amp_loop_pkg::DUTY_W_DEF,
  localparam int unsigned PROD_W = ACC_W + K_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [ACC_W-1:0]  acc_in,
  input  logic [K_W-1:0]    k_gain,
  output logic [DUTY_W-1:0] duty_q,
  output logic              vld_q,
  output logic              sat_q
);
  localparam logic [DUTY_W-1:0] DUTY_MAX = '1;

  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] scaled;
  logic              sat_d;
  logic [DUTY_W-1:0] duty_d;

  always_comb begin
    prod   = PROD_W'(acc_in) * PROD_W'(k_gain);
    scaled = prod >> K_FRAC;
    sat_d  = scaled >= PROD_W'(DUTY_MAX);
    duty_d = sat_d ? DUTY_MAX : scaled[DUTY_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_q <= '0;
      sat_q  <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= tick;
      if (tick) begin
        duty_q <= duty_d;
        sat_q  <= sat_d;
      end
    end
  end

  p_vld_after_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> vld_q);
  p_vld_only_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> !vld_q);
  p_duty_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_q |-> $stable(duty_q));
  p_sat_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sat_q |-> (duty_q == DUTY_MAX));
endmodule

// File: rtl/amp_level_loop.sv
module amp_level_loop #(
  parameter int unsigned LVL_W  = amp_loop_pkg::LVL_W_DEF,
  parameter int unsigned K_W    = amp_loop_pkg::K_W_DEF,
  parameter int unsigned K_FRAC = amp_loop_pkg::K_FRAC_DEF,
  parameter int unsigned DUTY_W = amp_loop_pkg::DUTY_W_DEF,
  parameter int unsigned ACC_W  = amp_loop_pkg::ACC_W_DEF,
  parameter int unsigned SYNC   = amp_loop_pkg::SYNC_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LVL_W-1:0]  setpoint,
  input  logic [LVL_W-1:0]  meas,
  input  logic              meas_tick,
  input  logic [K_W-1:0]    k_gain,
  output logic [DUTY_W-1:0] duty,
  output logic              duty_vld
);
  localparam int unsigned ERR_W = LVL_W + 1;

  logic [SYNC-1:0]         rst_pipe;
  logic                    rst_int_n;
  logic signed [ERR_W-1:0] err_q;
  logic [ACC_W-1:0]        acc_q;
  logic [ACC_W-1:0]        acc_nxt;
  logic                    sat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[SYNC-2:0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe[SYNC-1];

  amp_err_stage #(.LVL_W(LVL_W)) u_err (
    .clk(clk), .rst_n(rst_int_n), .tick(meas_tick),
    .setpoint(setpoint), .meas(meas), .err_q(err_q)
  );

  amp_integrator #(.LVL_W(LVL_W), .ACC_W(ACC_W)) u_int (
    .clk(clk), .rst_n(rst_int_n), .tick(meas_tick), .err_q(err_q),
    .sat_q(sat_q), .acc_q(acc_q), .acc_nxt(acc_nxt)
  );

  amp_gain_scale #(.ACC_W(ACC_W), .K_W(K_W), .K_FRAC(K_FRAC), .DUTY_W(DUTY_W)) u_scale (
    .clk(clk), .rst_n(rst_int_n), .tick(meas_tick), .acc_in(acc_nxt),
    .k_gain(k_gain), .duty_q(duty), .vld_q(duty_vld), .sat_q(sat_q)
  );

  p_zero_start_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (meas_tick && (acc_q == '0) && (err_q == '0)) |=> (duty == '0));
endmodule

// File: tb/sim_amp_level_loop.sv
`timescale 1ns/1ps
module sim_amp_level_loop;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] setpoint;
  logic [15:0] meas;
  logic        meas_tick;
  logic [15:0] k_gain;
  logic [11:0] duty;
  logic        duty_vld;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  longint m_err, m_acc, m_duty;
  bit     m_sat;

  always #2.5 clk = ~clk;

  amp_level_loop u0 (
    .clk(clk), .rst_n(rst_n), .setpoint(setpoint), .meas(meas),
    .meas_tick(meas_tick), .k_gain(k_gain), .duty(duty), .duty_vld(duty_vld)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; meas_tick = 1'b0; setpoint = '0; meas = '0; k_gain = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    m_err = 0; m_acc = 0; m_duty = 0; m_sat = 0;
  endtask

  // one control tick: expected duty from the requirements R4, R5, R6, R7, R8
  task automatic step(input int sp, input int ms, input int kk);
    longint cand, prod;
    logic [11:0] held;
    setpoint = 16'(sp); meas = 16'(ms); k_gain = 16'(kk); meas_tick = 1'b1;
    @(negedge clk);
    meas_tick = 1'b0;
    cand = (m_sat && m_err > 0) ? m_acc : m_acc + m_err;
    if (cand < 0) cand = 0;
    if (cand > 64'hFFFFFF) cand = 64'hFFFFFF;
    m_acc = cand;
    prod = (cand * kk) >>> 12;
    m_sat = (prod >= 4095);
    m_duty = m_sat ? 4095 : prod;
    m_err = sp - ms;
    chk("R2 vld after tick", duty_vld, 1);
    chk("R5 duty value", duty, m_duty);
    held = duty;
    @(negedge clk);
    chk("R2 vld one cycle", duty_vld, 0);
    chk("R3 duty held", duty, held);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 duty reset", duty, 0);
    chk("R1 vld reset", duty_vld, 0);
  endtask

  task automatic t_delay();
    do_reset();
    step(100, 0, 4096); chk("R4 first tick zero", duty, 0);
    step(100, 0, 4096); chk("R4 second tick", duty, 100);
    step(100, 0, 4096); chk("R4 third tick", duty, 200);
  endtask

  task automatic t_gain();
    do_reset();
    step(300, 200, 2048); chk("R5 half gain t1", duty, 0);
    step(300, 200, 2048); chk("R5 half gain t2", duty, 50);
    step(300, 200, 2048); chk("R5 half gain t3", duty, 100);
    step(300, 200, 6144); chk("R5 gain change", duty, 450);
  endtask

  task automatic t_floor();
    do_reset();
    for (int i = 0; i < 5; i++) step(100, 900, 4096);
    chk("R6 floor zero", duty, 0);
    step(540, 500, 4096); chk("R6 neg err still applied", duty, 0);
    step(540, 500, 4096); chk("R6 fast recovery", duty, 40);
  endtask

  task automatic t_sat();
    do_reset();
    step(4000, 0, 4096); chk("R7 sat t1", duty, 0);
    step(4000, 0, 4096); chk("R7 sat t2", duty, 4000);
    step(4000, 0, 4096); chk("R7 saturated", duty, 4095);
    step(4000, 0, 4096); chk("R8 hold t4", duty, 4095);
    step(4000, 0, 4096); chk("R8 hold t5", duty, 4095);
    step(0, 1000, 4096); chk("R8 held err", duty, 4095);
    step(0, 1000, 4096); chk("R8 unwind 1", duty, 4095);
    step(0, 1000, 4096); chk("R8 unwind 2", duty, 4095);
    step(0, 1000, 4096); chk("R8 unwind 3", duty, 4095);
    step(0, 1000, 4096); chk("R8 leaves saturation", duty, 4000);
    for (int i = 0; i < 3; i++) step(65535, 0, 65535);
    chk("R7 large gain no wrap", duty, 4095);
  endtask

  task automatic t_conv();
    int d;
    do_reset();
    for (int i = 0; i < 100; i++) step(1000, int'(duty), 1024);
    d = int'(duty) - 1000;
    if (d < 0) d = -d;
    chk("R9 converged", (d <= 10) ? 1 : 0, 1);
  endtask

  initial begin
    t_reset();
    t_delay();
    t_gain();
    t_floor();
    t_sat();
    t_conv();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule